// File: doc/BRIEF.md
# UART Transmit FIFO with Threshold Interrupt

This block is the transmit-side byte queue of one UART channel. The host loads characters through a transmit-holding write strobe, and the serializer takes them from the head through a pop handshake. The queue holds 64 bytes. It reports its free-slot count and its full and empty flags directly to the rest of the channel.

Two request outputs tell the host when to refill the queue. The transmitter-empty interrupt has two modes. In threshold mode it fires when enough slots are free, and it only re-arms after the host has loaded two characters. In plain mode it fires only when the queue runs dry. A write strobe or an interrupt-identification read services the interrupt. A separate rule decides whether draining to empty raises a new interrupt, and that rule depends on whether the last service included a write.

The DMA ready line uses its own hysteresis. It rises once the free space exceeds the selected level and falls only when the queue is full. A queue reset empties the queue and requests a refill at once.

Top module: `txq_top`

## Requirements
- R1: While reset is held, and after it is released with no other activity, the block shows `empty`=1, `full`=0, `free_cnt`=64, `irq`=0 and `tx_valid`=0. `dma_rdy` is 0 during reset and becomes 1 shortly after release.
- R2: Accepted bytes leave in write order. `tx_byte` shows the oldest byte whenever `tx_valid`=1. `free_cnt` equals 64 minus the number of stored bytes and updates on the clock edge that accepts a write or a pop.
- R3: A `fifo_clr` pulse empties the queue and sets `irq` at the same edge. In that cycle it overrides any write or pop.
- R4: A write while `full`=1 is dropped. The count stays the same and the stored bytes are not altered.
- R5: A pop while `empty`=1 is ignored, and the count does not change.
- R6: A write and a pop accepted in the same cycle leave `free_cnt` unchanged, and first-in-first-out order is kept.
- R7: `irq` falls at the edge that samples a `thr_wr` or `iir_rd` strobe, unless a set condition is true in that same cycle.
- R8: The level select `lvl_sel` maps 2'b00, 2'b01, 2'b10 and 2'b11 to 8, 16, 32 and 56 free slots.
- R9: With `thr_mode`=1, `irq` sets one edge after `free_cnt` is at or above the selected level. This happens only if at least two bytes have been accepted since the last interrupt event. Every interrupt event, including a queue reset, clears that tally.
- R10: A pop that empties the queue sets `irq` at that edge. The exception is `thr_mode`=1 with no byte accepted since the last interrupt event, which means the host serviced the interrupt only by a read.
- R11: With `thr_mode`=0, the free-space level never raises `irq`. Only draining to empty and a queue reset raise it.
- R12: `dma_rdy` rises one edge after `free_cnt` is seen above the selected level. It falls one edge after `full` is seen, and otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| thr_wr | input | 1 | Transmit holding write strobe |
| thr_wdata | input | 8 | Byte to enqueue |
| iir_rd | input | 1 | Interrupt-identification read strobe |
| fifo_clr | input | 1 | Transmit queue reset pulse |
| thr_mode | input | 1 | 1 = threshold interrupt mode, 0 = empty-only mode |
| lvl_sel | input | 2 | Free-slot level select |
| tx_pop | input | 1 | Serializer takes the head byte |
| tx_valid | output | 1 | Head byte available |
| tx_byte | output | 8 | Head byte |
| irq | output | 1 | Transmitter-empty interrupt |
| dma_rdy | output | 1 | DMA transfer request |
| free_cnt | output | 7 | Number of free slots (0 to 64) |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |

## Verification
The count, the flags and the head byte change at the edge that accepts an operation. A queue reset, a write or read strobe, and a pop that drains the queue all move `irq` at that same edge. A threshold interrupt is due one edge after the free count becomes visible, and so is any change of `dma_rdy`. Each directed task drives its inputs just after an edge and samples 1 ns after the edge that is due. Where a result lags by one edge, the task first checks that the old value is still present and then checks the new value after the next edge.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned TXQ_DEPTH  = 64;
  localparam int unsigned TXQ_DATA_W = 8;

  // Free-slot level for each select code, derived from the depth.
  function automatic int unsigned lvl_slots(input logic [1:0] sel, input int unsigned depth);
    unique case (sel)
      2'b00:   return depth / 8;
      2'b01:   return depth / 4;
      2'b10:   return depth / 2;
      default: return depth - depth / 8;
    endcase
  endfunction
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          drained
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~clr & ~full;
  assign pop_ok  = pop & ~clr & ~empty;
  assign drained = pop_ok & ~push_ok & (cnt_q == CW'(1));
  assign head    = mem[rp_q];
  assign cnt     = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end
endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_stb,
  input  logic          push_ok,
  input  logic          rd_stb,
  input  logic          mode,
  input  logic          drained,
  input  logic [CW-1:0] free,
  input  logic [CW-1:0] lvl,
  output logic          irq
);
  logic [1:0] wtally_q, wtally_d;
  logic       svc_q, svc_d;
  logic       irq_q, irq_d;
  logic       armed, thr_hit, empty_hit, fire;

  assign armed     = (wtally_q == 2'd2);
  assign thr_hit   = mode & armed & (free >= lvl);
  assign empty_hit = drained & (~mode | ~svc_q);
  assign fire      = clr | thr_hit | empty_hit;

  always_comb begin
    irq_d    = fire | (irq_q & ~(wr_stb | rd_stb));
    wtally_d = wtally_q;
    svc_d    = svc_q;
    if (fire) begin
      wtally_d = 2'd0;
      svc_d    = 1'b1;
    end else if (push_ok) begin
      svc_d = 1'b0;
      if (!armed) wtally_d = wtally_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      wtally_q <= 2'd0;
      svc_q    <= 1'b0;
    end else begin
      irq_q    <= irq_d;
      wtally_q <= wtally_d;
      svc_q    <= svc_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/txq_dma.sv
module txq_dma #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] free,
  input  logic [CW-1:0] lvl,
  input  logic          full,
  output logic          dma_rdy
);
  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (free > lvl)  req_d = 1'b1;
    else if (full)   req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign dma_rdy = req_q;
endmodule

// File: rtl/txq_top.sv
module txq_top #(
  parameter int DEPTH = txq_pkg::TXQ_DEPTH,
  parameter int W     = txq_pkg::TXQ_DATA_W,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_wr,
  input  logic [W-1:0]  thr_wdata,
  input  logic          iir_rd,
  input  logic          fifo_clr,
  input  logic          thr_mode,
  input  logic [1:0]    lvl_sel,
  input  logic          tx_pop,
  output logic          tx_valid,
  output logic [W-1:0]  tx_byte,
  output logic          irq,
  output logic          dma_rdy,
  output logic [CW-1:0] free_cnt,
  output logic          full,
  output logic          empty
);
  logic [1:0]    rs_q;
  logic          rst_int_n;
  logic [CW-1:0] cnt, free, lvl;
  logic          push_ok, pop_ok, drained;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  txq_store #(.DEPTH(DEPTH), .W(W)) store_i (
    .clk(clk), .rst_n(rst_int_n), .clr(fifo_clr), .push(thr_wr), .din(thr_wdata),
    .pop(tx_pop), .head(tx_byte), .cnt(cnt), .full(full), .empty(empty),
    .push_ok(push_ok), .pop_ok(pop_ok), .drained(drained)
  );

  assign free     = CW'(DEPTH) - cnt;
  assign lvl      = CW'(txq_pkg::lvl_slots(lvl_sel, DEPTH));
  assign free_cnt = free;
  assign tx_valid = ~empty;

  txq_irq #(.CW(CW)) irq_i (
    .clk(clk), .rst_n(rst_int_n), .clr(fifo_clr), .wr_stb(thr_wr), .push_ok(push_ok),
    .rd_stb(iir_rd), .mode(thr_mode), .drained(drained), .free(free), .lvl(lvl),
    .irq(irq)
  );

  txq_dma #(.CW(CW)) dma_i (
    .clk(clk), .rst_n(rst_int_n), .free(free), .lvl(lvl), .full(full),
    .dma_rdy(dma_rdy)
  );
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          thr_wr,
  input logic          iir_rd,
  input logic          fifo_clr,
  input logic          thr_mode,
  input logic          tx_pop,
  input logic          irq,
  input logic          dma_rdy,
  input logic [CW-1:0] free_cnt,
  input logic          full,
  input logic          empty
);
  a_r3_clr_empties_and_flags: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (irq && empty));

  a_r4_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (full && thr_wr && !tx_pop && !fifo_clr) |=> (full && free_cnt == '0));

  a_r5_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && tx_pop && !thr_wr && !fifo_clr) |=> empty);

  a_r6_simul_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !full && thr_wr && tx_pop && !fifo_clr) |=> $stable(free_cnt));

  a_r7_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && !thr_mode && !tx_pop && !fifo_clr) |=> !irq);

  a_r12_dma_drops_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> !dma_rdy);
endmodule

bind txq_top txq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .iir_rd(iir_rd), .fifo_clr(fifo_clr),
  .thr_mode(thr_mode), .tx_pop(tx_pop), .irq(irq), .dma_rdy(dma_rdy),
  .free_cnt(free_cnt), .full(full), .empty(empty)
);

// File: tb/txq_top_tb_top.sv
module txq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       thr_wr, iir_rd, fifo_clr, thr_mode, tx_pop;
  logic [7:0] thr_wdata;
  logic [1:0] lvl_sel;
  logic       tx_valid, irq, dma_rdy, full, empty;
  logic [7:0] tx_byte;
  logic [6:0] free_cnt;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  txq_top dut_i (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_wdata(thr_wdata), .iir_rd(iir_rd),
    .fifo_clr(fifo_clr), .thr_mode(thr_mode), .lvl_sel(lvl_sel), .tx_pop(tx_pop),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq), .dma_rdy(dma_rdy),
    .free_cnt(free_cnt), .full(full), .empty(empty)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [7:0] b);
    thr_wr = 1'b1; thr_wdata = b; step(); thr_wr = 1'b0;
  endtask

  task automatic pop_raw();
    tx_pop = 1'b1; step(); tx_pop = 1'b0;
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string tag);
    chk({tag, " valid"}, tx_valid, 1);
    chk({tag, " data"}, tx_byte, exp);
    pop_raw();
  endtask

  task automatic qclr();
    fifo_clr = 1'b1; step(); fifo_clr = 1'b0;
  endtask

  task automatic iird();
    iir_rd = 1'b1; step(); iir_rd = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(); step();
    chk("R1 empty in reset", empty, 1);
    chk("R1 full in reset", full, 0);
    chk("R1 free in reset", free_cnt, 64);
    chk("R1 irq in reset", irq, 0);
    chk("R1 valid in reset", tx_valid, 0);
    chk("R1 dma in reset", dma_rdy, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();
    chk("R1 irq after release", irq, 0);
    chk("R1 free after release", free_cnt, 64);
    chk("R1 dma after release", dma_rdy, 1);
  endtask

  task automatic t_order();
    qclr();
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
    chk("R2 free after 5 writes", free_cnt, 59);
    for (int i = 0; i < 5; i++) pop_chk(8'h10 + 8'(i), "R2 order");
    chk("R2 empty after drain", empty, 1);
  endtask

  task automatic t_full();
    qclr();
    for (int i = 0; i < 64; i++) push(8'(i) ^ 8'hA5);
    chk("R4 full flag", full, 1);
    chk("R4 free at full", free_cnt, 0);
    push(8'hEE);
    chk("R4 free after dropped write", free_cnt, 0);
    for (int i = 0; i < 64; i++) pop_chk(8'(i) ^ 8'hA5, "R4 contents kept");
    chk("R4 empty after drain", empty, 1);
  endtask

  task automatic t_pop_empty();
    qclr();
    pop_raw();
    chk("R5 free after empty pop", free_cnt, 64);
    chk("R5 valid after empty pop", tx_valid, 0);
    push(8'h77);
    pop_chk(8'h77, "R5 later write intact");
  endtask

  task automatic t_simul();
    qclr();
    push(8'h01); push(8'h02);
    chk("R6 head before both", tx_byte, 8'h01);
    thr_wr = 1'b1; thr_wdata = 8'h03; tx_pop = 1'b1;
    step();
    thr_wr = 1'b0; tx_pop = 1'b0;
    chk("R6 free unchanged", free_cnt, 62);
    pop_chk(8'h02, "R6 order");
    pop_chk(8'h03, "R6 order");
  endtask

  task automatic t_clr_and_read();
    thr_mode = 1'b0;
    qclr();
    push(8'h31); push(8'h32); push(8'h33);
    thr_wr = 1'b1; tx_pop = 1'b1; fifo_clr = 1'b1;
    step();
    thr_wr = 1'b0; tx_pop = 1'b0; fifo_clr = 1'b0;
    chk("R3 empty after clear", empty, 1);
    chk("R3 free after clear", free_cnt, 64);
    chk("R3 irq after clear", irq, 1);
    iird();
    chk("R7 read clears irq", irq, 0);
  endtask

  task automatic t_hyst();
    thr_mode = 1'b1; lvl_sel = 2'b11;
    qclr();
    iird();
    push(8'h41);
    chk("R9 no irq after one write", irq, 0);
    push(8'h42);
    chk("R9 no irq at second write edge", irq, 0);
    step();
    chk("R9 irq after two writes", irq, 1);
  endtask

  task automatic t_read_only();
    iird();
    chk("R7 read clears threshold irq", irq, 0);
    pop_chk(8'h41, "R10 drain");
    pop_chk(8'h42, "R10 drain");
    chk("R10 empty reached", empty, 1);
    chk("R10 no irq after read-only service", irq, 0);
    step(); step();
    chk("R10 still no irq", irq, 0);
  endtask

  task automatic t_write_service();
    qclr();
    chk("R3 irq set", irq, 1);
    push(8'h51);
    chk("R7 write clears irq", irq, 0);
    pop_chk(8'h51, "R10 drain");
    chk("R10 irq when drained after write", irq, 1);
  endtask

  task automatic t_level();
    thr_mode = 1'b0;
    qclr();
    iird();
    for (int i = 0; i < 10; i++) push(8'h60 + 8'(i));
    thr_mode = 1'b1; lvl_sel = 2'b11;
    step();
    chk("R8 no irq at 54 free", irq, 0);
    pop_raw();
    step();
    chk("R8 no irq at 55 free", irq, 0);
    pop_raw();
    chk("R9 irq not yet at 56 free", irq, 0);
    step();
    chk("R8 irq at 56 free", irq, 1);
  endtask

  task automatic t_mode_off();
    thr_mode = 1'b0; lvl_sel = 2'b11;
    qclr();
    iird();
    push(8'h71); push(8'h72);
    step(); step();
    chk("R11 no level irq in empty mode", irq, 0);
    pop_raw();
    chk("R11 no irq before empty", irq, 0);
    pop_raw();
    chk("R11 irq on drain", irq, 1);
  endtask

  task automatic t_dma(input logic [1:0] sel, input int lvl);
    lvl_sel = sel;
    qclr();
    step();
    chk("R12 dma up when empty", dma_rdy, 1);
    for (int i = 0; i < 63; i++) push(8'(i));
    chk("R12 dma holds below full", dma_rdy, 1);
    push(8'hFF);
    step();
    chk("R12 dma drops after full", dma_rdy, 0);
    for (int i = 0; i < lvl; i++) pop_raw();
    step();
    chk("R8 dma low at level", dma_rdy, 0);
    pop_raw();
    chk("R12 dma lag one edge", dma_rdy, 0);
    step();
    chk("R8 dma up above level", dma_rdy, 1);
    push(8'h00);
    step(); step();
    chk("R12 dma holds at level", dma_rdy, 1);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    thr_wr = 1'b0; iir_rd = 1'b0; fifo_clr = 1'b0; thr_mode = 1'b0; tx_pop = 1'b0;
    thr_wdata = 8'h00; lvl_sel = 2'b00;
    t_reset();
    t_order();
    t_full();
    t_pop_empty();
    t_simul();
    t_clr_and_read();
    t_hyst();
    t_read_only();
    t_write_service();
    t_level();
    t_mode_off();
    thr_mode = 1'b0;
    t_dma(2'b00, 8);
    t_dma(2'b01, 16);
    t_dma(2'b10, 32);
    t_dma(2'b11, 56);
    report();
  end
endmodule